// File: doc/BRIEF.md
# Sideband Command Frame Engine

This block is the client end of a byte-oriented sideband command link. An originator sends a frame one byte at a time over a valid/ready receive channel. The frame holds the target address, a write length, a read length, the write payload and a check byte. The engine compares the address with its strap input `dev_addr_i`. It keeps a running CRC-8 over the header and payload and compares that value with the received check byte. It decodes the command from the two length fields and then returns its reply on a valid/ready transmit channel.

When the check byte matches, the reply begins with the engine's own computed write checksum. This byte is the acknowledgement, so a presence probe to a live non-zero address always returns a non-zero byte. A device-information query follows it with an 8-byte record and a second CRC-8 computed over those eight bytes only. A length pair the engine does not support follows it with a single error completion byte and that byte's checksum. A frame for another address is consumed without any reaction. A frame with a corrupt check byte produces no reply and raises an error flag.

Top module: `sbfe_top`

## Requirements
- R1: The receive channel accepts bytes in this order: address, write length, read length, exactly write-length payload bytes, then one check byte. `rx_ready_o` is low whenever the transmit channel holds a byte.
- R2: The checksum is CRC-8 with polynomial 0x07, initial value 0x00, fed MSB first, with no final XOR. The write checksum covers the address, both length bytes and the payload. A probe frame to address 0x30 (0x30, 0x00, 0x00) yields 0xE1.
- R3: A frame whose address differs from `dev_addr_i` is consumed to its end. It produces no transmit byte and does not raise `fcs_err_o`. The next frame is decoded normally.
- R4: When the address matches but the check byte differs from the computed write checksum, no byte is transmitted. `fcs_err_o` then reads 1 from the cycle after that byte is accepted until the first byte of the next frame is accepted.
- R5: When the address and check byte both match, the first transmitted byte is the computed write checksum. For a probe (write length 0x00, read length 0x00) it is the only byte.
- R6: Write length 0x01 with read length 0x08 is the information query. After the acknowledge byte the engine sends eight bytes: REV_ID (default 0x41), NUM_DOMAINS (default 0x02), then six bytes of 0x00.
- R7: After the data bytes of a reply the engine sends a read checksum. It is computed over those data bytes only and starts from 0x00 for every reply.
- R8: Any other length pair is accepted through its check byte. The reply is then the acknowledge byte, one byte ERR_CODE (default 0x80) and that byte's read checksum.
- R9: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` stays unchanged.
- R10: After reset `rx_ready_o` is 1, `tx_valid_o` is 0 and `fcs_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_addr_i | input | 8 | Address this client answers to |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Engine can accept a receive byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Originator takes the transmit byte |
| fcs_err_o | output | 1 | Last addressed frame had a bad check byte |

## Verification
Probe frames are sent to two different addresses. This shows that the acknowledge byte is a real CRC of the header and not a constant, and the known 0xE1 value pins the CRC setting. Information queries, unsupported length pairs with a non-empty payload, corrupt check bytes and frames for a foreign address each have their own test. Together they separate correct decoding from a checksum that leaks between blocks, and a skipped frame from an errored one. Each silent case is followed by a probe, which proves that the engine consumed exactly one frame. A stalled transmit side checks that the reply byte holds steady until it is taken.

// File: rtl/sbfe_pkg.sv
package sbfe_pkg;
  typedef enum logic [2:0] {
    ST_ADDR, ST_WLEN, ST_RLEN, ST_WDATA, ST_WFCS, ST_ACK, ST_DATA, ST_RFCS
  } sbfe_state_e;

  typedef enum logic [1:0] {CMD_PING, CMD_INFO, CMD_BAD} sbfe_cmd_e;

  function automatic logic [7:0] crc8_step(logic [7:0] crc, logic [7:0] d,
                                           logic [7:0] poly);
    logic [7:0] c;
    c = crc ^ d;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ poly) : (c << 1);
    return c;
  endfunction
endpackage

// File: rtl/sbfe_crc8.sv
module sbfe_crc8 #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       en_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  import sbfe_pkg::*;
  logic [7:0] crc_q;

  // start_i seeds the block from zero on its first byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= 8'h00;
    else if (en_i) crc_q <= crc8_step(start_i ? 8'h00 : crc_q, data_i, POLY);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/sbfe_resp.sv
module sbfe_resp #(
  parameter int         INFO_LEN    = 8,
  parameter logic [7:0] REV_ID      = 8'h41,
  parameter logic [7:0] NUM_DOMAINS = 8'h02,
  parameter logic [7:0] ERR_CODE    = 8'h80,
  localparam int        IDX_W       = (INFO_LEN > 1) ? $clog2(INFO_LEN) : 1
) (
  input  sbfe_pkg::sbfe_cmd_e cmd_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [7:0]          byte_o,
  output logic                last_o
);
  import sbfe_pkg::*;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(INFO_LEN - 1);

  always_comb begin
    byte_o = 8'h00;
    last_o = 1'b1;
    unique case (cmd_i)
      CMD_INFO: begin
        last_o = (idx_i == LAST_IDX);
        if (idx_i == '0) byte_o = REV_ID;
        else if (idx_i == IDX_W'(1)) byte_o = NUM_DOMAINS;
      end
      CMD_BAD: byte_o = ERR_CODE;
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/sbfe_top.sv
module sbfe_top #(
  parameter int         INFO_LEN    = 8,
  parameter logic [7:0] REV_ID      = 8'h41,
  parameter logic [7:0] NUM_DOMAINS = 8'h02,
  parameter logic [7:0] ERR_CODE    = 8'h80,
  parameter logic [7:0] CRC_POLY    = 8'h07
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] dev_addr_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       rx_ready_o,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  input  logic       tx_ready_i,
  output logic       fcs_err_o
);
  import sbfe_pkg::*;
  localparam int IDX_W = (INFO_LEN > 1) ? $clog2(INFO_LEN) : 1;
  localparam logic [7:0] INFO_RLEN = 8'(INFO_LEN);

  sbfe_state_e      state_q;
  sbfe_cmd_e        cmd_q, cmd_d;
  logic             skip_q, err_q;
  logic [7:0]       wlen_q, cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       wcrc, rcrc, resp_byte;
  logic             resp_last, rx_fire, tx_fire;

  assign rx_ready_o = (state_q inside {ST_ADDR, ST_WLEN, ST_RLEN, ST_WDATA, ST_WFCS});
  assign tx_valid_o = (state_q inside {ST_ACK, ST_DATA, ST_RFCS});
  assign rx_fire    = rx_valid_i && rx_ready_o;
  assign tx_fire    = tx_valid_o && tx_ready_i;
  assign fcs_err_o  = err_q;

  sbfe_crc8 #(.POLY(CRC_POLY)) u_wcrc (
    .clk_i, .rst_ni,
    .start_i(state_q == ST_ADDR),
    .en_i   (rx_fire && state_q != ST_WFCS),
    .data_i (rx_data_i),
    .crc_o  (wcrc)
  );

  sbfe_crc8 #(.POLY(CRC_POLY)) u_rcrc (
    .clk_i, .rst_ni,
    .start_i(idx_q == '0),
    .en_i   (tx_fire && state_q == ST_DATA),
    .data_i (resp_byte),
    .crc_o  (rcrc)
  );

  sbfe_resp #(
    .INFO_LEN(INFO_LEN), .REV_ID(REV_ID),
    .NUM_DOMAINS(NUM_DOMAINS), .ERR_CODE(ERR_CODE)
  ) u_resp (
    .cmd_i(cmd_q), .idx_i(idx_q), .byte_o(resp_byte), .last_o(resp_last)
  );

  // command is picked from the length pair while read length arrives
  always_comb begin
    if (wlen_q == 8'h00 && rx_data_i == 8'h00)   cmd_d = CMD_PING;
    else if (wlen_q == 8'h01 && rx_data_i == INFO_RLEN) cmd_d = CMD_INFO;
    else                                         cmd_d = CMD_BAD;
  end

  always_comb begin
    unique case (state_q)
      ST_ACK:  tx_data_o = wcrc;
      ST_DATA: tx_data_o = resp_byte;
      ST_RFCS: tx_data_o = rcrc;
      default: tx_data_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ADDR;
      cmd_q   <= CMD_PING;
      skip_q  <= 1'b0;
      err_q   <= 1'b0;
      wlen_q  <= 8'h00;
      cnt_q   <= 8'h00;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (rx_fire) begin
          skip_q  <= (rx_data_i != dev_addr_i);
          err_q   <= 1'b0;
          state_q <= ST_WLEN;
        end
        ST_WLEN: if (rx_fire) begin
          wlen_q  <= rx_data_i;
          state_q <= ST_RLEN;
        end
        ST_RLEN: if (rx_fire) begin
          cmd_q   <= cmd_d;
          cnt_q   <= wlen_q;
          state_q <= (wlen_q == 8'h00) ? ST_WFCS : ST_WDATA;
        end
        ST_WDATA: if (rx_fire) begin
          cnt_q <= cnt_q - 8'd1;
          if (cnt_q == 8'd1) state_q <= ST_WFCS;
        end
        ST_WFCS: if (rx_fire) begin
          if (skip_q) state_q <= ST_ADDR;
          else if (rx_data_i == wcrc) state_q <= ST_ACK;
          else begin
            err_q   <= 1'b1;
            state_q <= ST_ADDR;
          end
        end
        ST_ACK: if (tx_fire) begin
          idx_q   <= '0;
          state_q <= (cmd_q == CMD_PING) ? ST_ADDR : ST_DATA;
        end
        ST_DATA: if (tx_fire) begin
          idx_q <= idx_q + IDX_W'(1);
          if (resp_last) state_q <= ST_RFCS;
        end
        ST_RFCS: if (tx_fire) state_q <= ST_ADDR;
        default: state_q <= ST_ADDR;
      endcase
    end
  end
endmodule

// File: rtl/sbfe_checker.sv
module sbfe_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_ready_o,
  input logic       tx_valid_o,
  input logic [7:0] tx_data_o,
  input logic       tx_ready_i,
  input logic       fcs_err_o,
  input logic       skip_q
);
  p_half_duplex_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_ready_o && tx_valid_o));

  p_skip_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_q |-> (!tx_valid_o && !fcs_err_o));

  p_err_silent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcs_err_o |-> !tx_valid_o);

  p_err_after_rx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fcs_err_o) |-> $past(rx_ready_o));

  p_tx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

bind sbfe_top sbfe_checker u_sbfe_checker (
  .clk_i, .rst_ni, .rx_ready_o, .tx_valid_o, .tx_data_o,
  .tx_ready_i, .fcs_err_o, .skip_q
);

// File: tb/sbfe_top_bench.sv
module sbfe_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dev_addr = 8'h30;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_ready, tx_valid, tx_ready = 1'b0, fcs_err;
  logic [7:0] tx_data;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  sbfe_top u_sbfe_top (
    .clk_i(clk), .rst_ni(rst_n), .dev_addr_i(dev_addr),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .fcs_err_o(fcs_err)
  );

  function automatic logic [7:0] crc_step(logic [7:0] c, logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // sends addr, wlen, rlen, payload, then check byte (good or flipped)
  task automatic send_frame(input logic [7:0] f[], input bit corrupt);
    logic [7:0] c = 8'h00;
    foreach (f[i]) begin
      c = crc_step(c, f[i]);
      send_byte(f[i]);
    end
    send_byte(corrupt ? ~c : c);
  endtask

  task automatic recv(output logic [7:0] b, output bit got, input int stall,
                      input string req);
    int n = 0;
    bit held = 1'b1;
    @(negedge clk);
    while (!tx_valid && n < 20) begin @(negedge clk); n++; end
    got = tx_valid;
    b = tx_data;
    if (!got) return;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      if (!tx_valid || tx_data != b) held = 1'b0;
    end
    if (stall > 0) chk(held, req, "byte held under stall", tx_data, b);
    tx_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic expect_reply(input logic [7:0] e[], input string req, input int stall);
    logic [7:0] b;
    bit got;
    foreach (e[i]) begin
      recv(b, got, stall, req);
      chk(got && b == e[i], req, $sformatf("reply byte %0d", i), got ? b : 'hx, e[i]);
    end
  endtask

  task automatic expect_silence(input string req);
    bit quiet = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (tx_valid) quiet = 1'b0;
    end
    chk(quiet, req, "no transmit byte", tx_valid, 0);
  endtask

  function automatic logic [7:0] crc_of(input logic [7:0] f[]);
    logic [7:0] c = 8'h00;
    foreach (f[i]) c = crc_step(c, f[i]);
    return c;
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk(rx_ready == 1'b1, "R10", "rx_ready after reset", rx_ready, 1);
    chk(tx_valid == 1'b0, "R10", "tx_valid after reset", tx_valid, 0);
    chk(fcs_err == 1'b0, "R10", "fcs_err after reset", fcs_err, 0);
  endtask

  task automatic t_ping;
    logic [7:0] f[] = '{8'h30, 8'h00, 8'h00};
    chk(crc_of(f) == 8'he1, "R2", "bench crc of probe", crc_of(f), 8'he1);
    send_frame(f, 1'b0);
    chk(fcs_err == 1'b0, "R2", "good probe check byte", fcs_err, 0);
    chk(rx_ready == 1'b0, "R1", "rx_ready low during reply", rx_ready, 0);
    expect_reply('{8'he1}, "R5", 0);
    expect_silence("R5");
    dev_addr = 8'h5a;
    f = '{8'h5a, 8'h00, 8'h00};
    send_frame(f, 1'b0);
    expect_reply('{crc_of(f)}, "R2", 0);
    chk(crc_of(f) != 8'h00, "R5", "probe ack non-zero", crc_of(f), 1);
    expect_silence("R5");
    dev_addr = 8'h30;
  endtask

  task automatic t_info(input int stall);
    logic [7:0] f[] = '{8'h30, 8'h01, 8'h08, 8'hf7};
    logic [7:0] d[] = '{8'h41, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send_frame(f, 1'b0);
    expect_reply('{crc_of(f)}, "R5", stall);
    expect_reply(d, "R6", stall);
    expect_reply('{crc_of(d)}, "R7", stall);
    expect_silence("R6");
  endtask

  task automatic t_bad_fcs;
    logic [7:0] f[] = '{8'h30, 8'h01, 8'h08, 8'h12};
    send_frame(f, 1'b1);
    chk(fcs_err == 1'b1, "R4", "error flag after bad check byte", fcs_err, 1);
    expect_silence("R4");
    chk(fcs_err == 1'b1, "R4", "error flag holds", fcs_err, 1);
    send_byte(8'h30);
    chk(fcs_err == 1'b0, "R4", "error flag cleared by next frame", fcs_err, 0);
    send_byte(8'h00);
    send_byte(8'h00);
    send_byte(8'he1);
    expect_reply('{8'he1}, "R4", 0);
  endtask

  task automatic t_foreign;
    logic [7:0] f[] = '{8'h31, 8'h03, 8'h08, 8'h30, 8'h00, 8'h00};
    send_frame(f, 1'b0);
    chk(fcs_err == 1'b0, "R3", "no error on foreign frame", fcs_err, 0);
    expect_silence("R3");
    send_frame(f, 1'b1);
    chk(fcs_err == 1'b0, "R3", "no error on corrupt foreign frame", fcs_err, 0);
    expect_silence("R3");
    send_frame('{8'h30, 8'h00, 8'h00}, 1'b0);
    expect_reply('{8'he1}, "R3", 0);
  endtask

  task automatic t_unsupported;
    logic [7:0] f[] = '{8'h30, 8'h02, 8'h04, 8'haa, 8'hbb};
    send_frame(f, 1'b0);
    expect_reply('{crc_of(f), 8'h80, crc_step(8'h00, 8'h80)}, "R8", 0);
    expect_silence("R8");
    f = '{8'h30, 8'h00, 8'h04};
    send_frame(f, 1'b0);
    expect_reply('{crc_of(f), 8'h80, crc_step(8'h00, 8'h80)}, "R7", 0);
    expect_silence("R8");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ping();
    t_info(0);
    t_info(3);   // R9 stalled transmit side
    t_bad_fcs();
    t_foreign();
    t_unsupported();
    t_info(0);   // R7 read checksum restarts per reply
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule